// File: doc/BRIEF.md
# Bus Cycle Classifier for an 8-bit Processor Bus

This block watches the active-low control strobes of a classic 8-bit microprocessor bus (machine-cycle-one, read, write, memory request and I/O request) together with the 8-bit data bus and the 16-bit address bus. It samples them on its own clock. Every sample is sorted into exactly one bus-cycle type, and the block tracks the moments where a cycle starts, finishes, or jumps straight to another type.

The address is captured on the first active sample of a cycle. The data byte is refreshed on every active sample. When the strobes return to idle, the block emits a one-clock event that carries the finished cycle's type, a coarse read/write class, the captured address and the last data byte. A direct change between two active types counts as a protocol violation. It raises a warning pulse, and the broken cycle produces no event. The block is meant as a front end for bus tracing or protocol checking logic.

Top module: `zbus_cycle_mon`

## Requirements
- R1: Cycle types are encoded NONE=0, MEMRD=1, MEMWR=2, IORD=3, IOWR=4, FETCH=5, INTACK=6. While reset is high and in the cycle after it, every output is zero.
- R2: With memory request low, a low read strobe gives FETCH when machine-cycle-one is low and MEMRD otherwise. The read strobe wins over the write strobe. With the read strobe high, a low write strobe gives MEMWR.
- R3: I/O decoding applies only when memory request is high and I/O request is low. Machine-cycle-one low gives INTACK. Otherwise a low read strobe gives IORD, and otherwise a low write strobe gives IOWR. Memory request low overrides I/O request low.
- R4: Inputs pass through a two-stage synchronizer. A strobe change applied before clock edge k shows on the registered outputs after edge k+2.
- R5: The address is captured on the first active sample of a cycle. Address changes later in the same cycle do not alter the reported address.
- R6: The reported data byte is the one present on the last active sample of the cycle.
- R7: A change from an active type to NONE produces exactly one single-clock evt_valid pulse. The pulse carries the previous type. A cycle of a single active sample is also reported.
- R8: evt_kind is 0 for memory read (MEMRD or FETCH), 1 for MEMWR, 2 for I/O read (IORD or INTACK) and 3 for IOWR.
- R9: A direct change between two different active types gives a one-clock illegal_pulse. That cycle ends without an event, and the next cycle that starts from NONE is reported normally.
- R10: Strobe patterns that select no type are NONE and produce no event. These are memory request low with neither read nor write low, and I/O request alone without machine-cycle-one, read or write low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| data_in | input | 8 | Data bus |
| addr_in | input | 16 | Address bus |
| evt_valid | output | 1 | One-clock pulse at the end of a clean cycle |
| evt_type | output | 3 | Type of the finished cycle |
| evt_kind | output | 2 | Read/write class of the finished cycle |
| evt_addr | output | 16 | Address captured at cycle start |
| evt_data | output | 8 | Last data byte of the cycle |
| illegal_pulse | output | 1 | One-clock pulse on a direct type change |

## Verification
The bench targets strobe overlaps where priority decides the type. These include read and write low together, memory and I/O request low together, and machine-cycle-one with I/O request, so a wrong priority shows up as a wrong evt_type. An address that moves mid-cycle and data that changes on the last sample catch a design that captures at the wrong moment. A single-sample cycle and cycles one idle sample apart catch a missed or doubled end pulse. A direct memory-read to memory-write change, followed by a clean I/O cycle, shows whether the tainted cycle is suppressed and whether the flag clears again at the next start.

// File: rtl/zbus_pkg.sv
package zbus_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_MEMRD  = 3'd1,
        CYC_MEMWR  = 3'd2,
        CYC_IORD   = 3'd3,
        CYC_IOWR   = 3'd4,
        CYC_FETCH  = 3'd5,
        CYC_INTACK = 3'd6
    } cyc_e;

    typedef enum logic [1:0] {
        KIND_MEM_RD = 2'd0,
        KIND_MEM_WR = 2'd1,
        KIND_IO_RD  = 2'd2,
        KIND_IO_WR  = 2'd3
    } kind_e;

    typedef struct packed {
        logic m1_n;
        logic rd_n;
        logic wr_n;
        logic mreq_n;
        logic iorq_n;
    } strobes_t;

    localparam int STROBE_W = $bits(strobes_t);

    typedef struct packed {
        strobes_t            strb;
        logic [DATA_W-1:0]   data;
        logic [ADDR_W-1:0]   addr;
    } sample_t;

    localparam int SAMPLE_W = $bits(sample_t);

    localparam sample_t SAMPLE_IDLE = '{
        strb: '{m1_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, mreq_n: 1'b1, iorq_n: 1'b1},
        data: '0,
        addr: '0
    };

    typedef struct packed {
        logic               valid;
        cyc_e               kind_src;
        kind_e              kind;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
    } event_t;

    function automatic kind_e kind_of(cyc_e c);
        case (c)
            CYC_MEMRD, CYC_FETCH: return KIND_MEM_RD;
            CYC_MEMWR:            return KIND_MEM_WR;
            CYC_IORD, CYC_INTACK: return KIND_IO_RD;
            default:              return KIND_IO_WR;
        endcase
    endfunction

endpackage

// File: rtl/zbus_sync.sv
module zbus_sync #(
    parameter int                W         = 8,
    parameter int                STAGES    = 2,
    parameter logic [W-1:0]      RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RESET_VAL;
                else     stage_q[s] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= RESET_VAL;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/zbus_decode.sv
module zbus_decode
    import zbus_pkg::*;
(
    input  strobes_t strb,
    output cyc_e     cyc
);
    always_comb begin
        cyc = CYC_NONE;
        if (!strb.mreq_n) begin
            if (!strb.rd_n)      cyc = strb.m1_n ? CYC_MEMRD : CYC_FETCH;
            else if (!strb.wr_n) cyc = CYC_MEMWR;
        end else if (!strb.iorq_n) begin
            if (!strb.m1_n)      cyc = CYC_INTACK;
            else if (!strb.rd_n) cyc = CYC_IORD;
            else if (!strb.wr_n) cyc = CYC_IOWR;
        end
    end
endmodule

// File: rtl/zbus_tracker.sv
module zbus_tracker
    import zbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cyc_e               cur,
    input  logic [DATA_W-1:0]  s_data,
    input  logic [ADDR_W-1:0]  s_addr,
    output event_t             evt,
    output logic               illegal
);
    cyc_e              prev_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              tainted_q;

    logic cur_act, prev_act, is_begin, is_end, is_jump;

    always_comb begin
        cur_act  = (cur != CYC_NONE);
        prev_act = (prev_q != CYC_NONE);
        is_begin = !prev_act && cur_act;
        is_end   = prev_act && !cur_act;
        is_jump  = prev_act && cur_act && (cur != prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= CYC_NONE;
            addr_q    <= '0;
            data_q    <= '0;
            tainted_q <= 1'b0;
            evt       <= '0;
            illegal   <= 1'b0;
        end else begin
            evt.valid <= 1'b0;
            illegal   <= 1'b0;
            if (cur_act) data_q <= s_data;
            if (is_begin) begin
                addr_q    <= s_addr;
                tainted_q <= 1'b0;
            end
            if (is_end && !tainted_q) begin
                evt.valid    <= 1'b1;
                evt.kind_src <= prev_q;
                evt.kind     <= kind_of(prev_q);
                evt.addr     <= addr_q;
                evt.data     <= data_q;
            end
            if (is_jump) begin
                illegal   <= 1'b1;
                tainted_q <= 1'b1;
            end
            prev_q <= cur;
        end
    end

    // R7: an end pulse never lasts two clocks
    assert_evt_single_R7: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);
    // R7: a reported cycle always carries an active type
    assert_evt_type_active_R7: assert property (@(posedge clk) disable iff (rst)
        evt.valid |-> (evt.kind_src != CYC_NONE));
    // R9: warning and event never coincide
    assert_warn_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(evt.valid && illegal));
    // R9: the cycle that jumped types cannot be reported on the next clock
    assert_no_evt_after_warn_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !evt.valid);
    // R8: read kinds only come from read types
    assert_kind_read_R8: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.kind == KIND_MEM_RD) |->
            (evt.kind_src == CYC_MEMRD || evt.kind_src == CYC_FETCH));
endmodule

// File: rtl/zbus_cycle_mon.sv
module zbus_cycle_mon
    import zbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 m1_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 mreq_n,
    input  logic                 iorq_n,
    input  logic [DATA_W-1:0]    data_in,
    input  logic [ADDR_W-1:0]    addr_in,
    output logic                 evt_valid,
    output logic [2:0]           evt_type,
    output logic [1:0]           evt_kind,
    output logic [ADDR_W-1:0]    evt_addr,
    output logic [DATA_W-1:0]    evt_data,
    output logic                 illegal_pulse
);
    sample_t raw_s, sync_s;
    cyc_e    cur;
    event_t  evt;

    always_comb begin
        raw_s.strb.m1_n   = m1_n;
        raw_s.strb.rd_n   = rd_n;
        raw_s.strb.wr_n   = wr_n;
        raw_s.strb.mreq_n = mreq_n;
        raw_s.strb.iorq_n = iorq_n;
        raw_s.data        = data_in;
        raw_s.addr        = addr_in;
    end

    zbus_sync #(
        .W         (SAMPLE_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (SAMPLE_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_s),
        .q   (sync_s)
    );

    zbus_decode u_decode (
        .strb (sync_s.strb),
        .cyc  (cur)
    );

    zbus_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .cur     (cur),
        .s_data  (sync_s.data),
        .s_addr  (sync_s.addr),
        .evt     (evt),
        .illegal (illegal_pulse)
    );

    assign evt_valid = evt.valid;
    assign evt_type  = evt.kind_src;
    assign evt_kind  = evt.kind;
    assign evt_addr  = evt.addr;
    assign evt_data  = evt.data;
endmodule

// File: tb/test_zbus_cycle_mon.sv
module test_zbus_cycle_mon;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m1_n = 1, rd_n = 1, wr_n = 1, mreq_n = 1, iorq_n = 1;
    logic [7:0]  data_in = '0;
    logic [15:0] addr_in = '0;
    logic        evt_valid, illegal_pulse;
    logic [2:0]  evt_type;
    logic [1:0]  evt_kind;
    logic [15:0] evt_addr;
    logic [7:0]  evt_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    zbus_cycle_mon i_zbus_cycle_mon (
        .clk(clk), .rst(rst), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .data_in(data_in), .addr_in(addr_in),
        .evt_valid(evt_valid), .evt_type(evt_type), .evt_kind(evt_kind),
        .evt_addr(evt_addr), .evt_data(evt_data), .illegal_pulse(illegal_pulse)
    );

    // reference model state: a queue of raw samples stands in for the pipeline delay
    int q_in[$];
    int m_prev = 0, m_addr = 0, m_data = 0, m_taint = 0;
    int e_valid = 0, e_type = 0, e_kind = 0, e_addr = 0, e_data = 0, e_ill = 0;
    int n_events = 0, n_warns = 0;

    function automatic int pack_in();
        return {m1_n, rd_n, wr_n, mreq_n, iorq_n, data_in, addr_in};
    endfunction

    function automatic int ref_type(int s);
        int m1, rd, wr, mq, io;
        m1 = (s >> 28) & 1; rd = (s >> 27) & 1; wr = (s >> 26) & 1;
        mq = (s >> 25) & 1; io = (s >> 24) & 1;
        if (mq == 0) begin
            if (rd == 0) return (m1 == 0) ? 5 : 1;
            if (wr == 0) return 2;
            return 0;
        end
        if (io == 0) begin
            if (m1 == 0) return 6;
            if (rd == 0) return 3;
            if (wr == 0) return 4;
        end
        return 0;
    endfunction

    function automatic int ref_kind(int t);
        if (t == 1 || t == 5) return 0;
        if (t == 2) return 1;
        if (t == 3 || t == 6) return 2;
        return 3;
    endfunction

    task automatic model_step();
        int s, t;
        if (rst) begin
            q_in.delete();
            q_in.push_back(32'h1F00_0000);
            q_in.push_back(32'h1F00_0000);
            m_prev = 0; m_addr = 0; m_data = 0; m_taint = 0;
            e_valid = 0; e_type = 0; e_kind = 0; e_addr = 0; e_data = 0; e_ill = 0;
            return;
        end
        s = q_in.pop_front();
        q_in.push_back(pack_in());
        t = ref_type(s);
        e_valid = 0; e_ill = 0;
        if (m_prev == 0 && t != 0) begin
            m_addr = s & 16'hFFFF; m_taint = 0;
        end else if (m_prev != 0 && t == 0) begin
            if (m_taint == 0) begin
                e_valid = 1; e_type = m_prev; e_kind = ref_kind(m_prev);
                e_addr = m_addr; e_data = m_data; n_events++;
            end
        end else if (m_prev != 0 && t != m_prev) begin
            e_ill = 1; m_taint = 1; n_warns++;
        end
        if (t != 0) m_data = (s >> 16) & 8'hFF;
        m_prev = t;
    endtask

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h",
                     cur_req, what, cycles, act, exp);
        end
    endtask

    task automatic compare();
        check(evt_valid === e_valid[0], "evt_valid", evt_valid, e_valid);
        check(illegal_pulse === e_ill[0], "illegal_pulse", illegal_pulse, e_ill);
        check(evt_type === e_type[2:0] && evt_kind === e_kind[1:0],
              "type/kind", {evt_type, evt_kind}, {e_type[2:0], e_kind[1:0]});
        check(evt_addr === e_addr[15:0] && evt_data === e_data[7:0],
              "addr/data", {evt_addr, evt_data}, {e_addr[15:0], e_data[7:0]});
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        cycles++;
        compare();
    endtask

    task automatic bus(input logic m1, rd, wr, mq, io, input logic [7:0] d,
                       input logic [15:0] a, input int n);
        m1_n = m1; rd_n = rd; wr_n = wr; mreq_n = mq; iorq_n = io;
        data_in = d; addr_in = a;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic idle(input int n);
        bus(1, 1, 1, 1, 1, 8'h00, 16'h0000, n);
    endtask

    // a completed event is checked explicitly, three clocks after the strobes go idle (R4)
    task automatic expect_event(input int typ, input int kind, input int a, input int d);
        idle(2);
        tick();
        check(evt_valid === 1'b1, "event pulse", evt_valid, 1);
        check(evt_type === typ[2:0], "event type", evt_type, typ);
        check(evt_kind === kind[1:0], "event kind", evt_kind, kind);
        check(evt_addr === a[15:0] && evt_data === d[7:0], "event addr/data",
              {evt_addr, evt_data}, {a[15:0], d[7:0]});
        idle(2);
    endtask

    initial begin
        int ev0;
        cur_req = "R1";
        rst = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        check(evt_valid === 0 && illegal_pulse === 0 && evt_addr === 0 &&
              evt_data === 0 && evt_type === 0, "reset state",
              {evt_valid, illegal_pulse, evt_type}, 0);
        rst = 1'b0;
        idle(3);

        cur_req = "R2";  // fetch, address moves mid-cycle (R5), data changes last (R6)
        bus(0, 0, 1, 0, 1, 8'h3E, 16'h1234, 3);
        cur_req = "R5";
        bus(0, 0, 1, 0, 1, 8'h55, 16'h9999, 2);
        cur_req = "R6";
        expect_event(5, 0, 16'h1234, 8'h55);

        cur_req = "R2";  // read and write both low: read wins
        bus(1, 0, 0, 0, 1, 8'hA1, 16'h0100, 3);
        expect_event(1, 0, 16'h0100, 8'hA1);
        bus(1, 1, 0, 0, 1, 8'hB2, 16'h0200, 2);
        expect_event(2, 1, 16'h0200, 8'hB2);

        cur_req = "R3";  // I/O types and memory-over-I/O priority
        bus(1, 0, 1, 1, 0, 8'hC3, 16'h00F0, 2);
        expect_event(3, 2, 16'h00F0, 8'hC3);
        bus(1, 1, 0, 1, 0, 8'hD4, 16'h00F1, 2);
        expect_event(4, 3, 16'h00F1, 8'hD4);
        bus(0, 1, 1, 1, 0, 8'hFF, 16'h0038, 2);
        expect_event(6, 2, 16'h0038, 8'hFF);
        bus(1, 1, 0, 0, 0, 8'h11, 16'h4000, 2);
        expect_event(2, 1, 16'h4000, 8'h11);

        cur_req = "R8";
        bus(0, 0, 0, 1, 0, 8'h22, 16'h0066, 2);
        expect_event(6, 2, 16'h0066, 8'h22);

        cur_req = "R10";  // strobes that select nothing
        ev0 = n_events;
        bus(1, 1, 1, 0, 1, 8'h77, 16'h7777, 3);
        bus(1, 1, 1, 1, 0, 8'h78, 16'h7778, 3);
        idle(4);
        check(n_events == ev0 && evt_valid === 0, "no event for empty strobes",
              n_events - ev0, 0);

        cur_req = "R7";  // single-sample cycle, then two cycles one idle apart
        bus(1, 0, 1, 0, 1, 8'h5A, 16'h2222, 1);
        expect_event(1, 0, 16'h2222, 8'h5A);
        ev0 = n_events;
        bus(1, 0, 1, 0, 1, 8'h01, 16'h3000, 2);
        idle(1);
        bus(1, 1, 0, 0, 1, 8'h02, 16'h3001, 2);
        idle(5);
        check(n_events - ev0 == 2, "two back-to-back events", n_events - ev0, 2);

        cur_req = "R9";  // direct type change, suppressed end, clean recovery
        ev0 = n_events;
        bus(1, 0, 1, 0, 1, 8'h90, 16'h5000, 3);
        bus(1, 1, 0, 0, 1, 8'h91, 16'h5001, 3);
        idle(5);
        check(n_events == ev0 && n_warns > 0, "jump gives warning and no event",
              n_events - ev0, 0);
        bus(1, 1, 0, 1, 0, 8'h92, 16'h5002, 2);
        expect_event(4, 3, 16'h5002, 8'h92);

        cur_req = "R4";
        bus(1, 0, 1, 0, 1, 8'h44, 16'h4444, 2);
        idle(2);
        check(evt_valid === 0, "no pulse before third edge", evt_valid, 0);
        tick();
        check(evt_valid === 1, "pulse on third edge", evt_valid, 1);
        idle(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog %s: actual=hung expected=done", cur_req);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule